// File: doc/BRIEF.md
# Rotating-Parity Block Array Controller

This controller presents one logical block space to a host and spreads it over N+1 block-storage ports. Logical blocks are grouped N at a time into stripes. Each stripe occupies the same address on every disk. One disk in each stripe holds the XOR of the stripe's data blocks, and that parity position moves to a different disk on each successive stripe.

A host write updates one data block. The controller first reads the old data block and the old parity block, then writes the new data and the new parity. A host read touches only the disk that holds the block.

The host marks failed disks on a status input. With one disk failed, a read aimed at that disk is rebuilt from every surviving disk in the stripe. Requests that cannot be served safely end with an error flag and leave every disk unwritten. The controller serves one host request at a time.

Top module: `stripe_ctrl`

## Requirements
- R1: Logical block `b` lies in stripe `s = b / N` at data position `j = b % N`, and `dk_addr` carries `s`. Its data disk is `j` when `j` is below the parity disk, and `j+1` otherwise. Valid block numbers are below `N * 2^SW`.
- R2: The parity disk of stripe `s` is `N - (s % (N+1))`.
- R3: After any write made with no disk failed, the parity block of the stripe equals the XOR of the stripe's data blocks. As a result, the XOR over all N+1 disks at that address is zero.
- R4: With both the target disk and the parity disk healthy, a write makes exactly four accesses: one read and one write on the target disk, and one read and one write on the parity disk. Both reads are acknowledged before either write is requested. The new parity is old parity XOR old data XOR new data.
- R5: A read whose target disk is healthy makes one read access, on the target disk only, and returns that disk's word.
- R6: With exactly one disk failed, a read aimed at that disk reads every other disk once and returns the XOR of their words. No request ever goes to a disk marked failed.
- R7: `host_ready` is high only when no request is in progress. It is low whenever any disk request is raised. Each accepted request produces one `resp_valid` pulse of one cycle. `resp_err` is 0 on a successful response.
- R8: A disk request stays raised until that disk acknowledges it. While it waits, `dk_we` and `dk_addr` do not change.
- R9: A write whose target disk is marked failed completes with `resp_err = 1` and makes no disk access.
- R10: Any request made while two or more disks are marked failed completes with `resp_err = 1` and makes no disk access.
- R11: A write whose parity disk is marked failed (and whose target is healthy) reads and writes only the target disk.
- R12: After reset, `host_ready` is 1, no disk request is raised and `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Controller can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_lba | input | LW | Logical block number |
| host_wdata | input | DW | Write data word |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Request refused |
| resp_rdata | output | DW | Read result |
| disk_bad | input | N+1 | Failed-disk mask, bit i = disk i |
| dk_req | output | N+1 | Per-disk request |
| dk_we | output | 1 | Request is a write (common to all disks) |
| dk_addr | output | SW | Stripe address (common to all disks) |
| dk_wdata | output | (N+1)×DW | Per-disk write word |
| dk_ack | input | N+1 | Per-disk acknowledge, one cycle |
| dk_rdata | input | (N+1)×DW | Per-disk read word, valid with acknowledge |

## Verification
The bench builds the controller with N=3, 16-bit words and 4-bit stripe addresses. With 4 disks, the parity position passes through all four disks within stripes 0 to 3. The top block number (47) reaches the last stripe. Each disk model answers after a different delay, so reads for one request complete out of order. That lets the bench test that both reads finish before any write. Failure masks cover a failed target, a failed parity disk, a failed bystander disk and double failures.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } seq_t;
endpackage

// File: rtl/stripe_map.sv
// Logical block -> stripe, data disk and parity disk.
module stripe_map #(
  parameter int N  = 3,
  parameter int LW = 12,
  parameter int SW = 10,
  parameter int IW = 2
) (
  input  logic [LW-1:0] lba,
  output logic [SW-1:0] stripe,
  output logic [IW-1:0] tgt,
  output logic [IW-1:0] par
);
  localparam logic [LW-1:0] NL  = LW'(N);
  localparam logic [LW-1:0] NDL = LW'(N + 1);

  logic [LW-1:0] s_l, j_l, p_l;

  assign s_l    = lba / NL;
  assign j_l    = lba % NL;
  // parity walks downward one disk per stripe
  assign p_l    = NL - (s_l % NDL);
  assign stripe = SW'(s_l);
  assign par    = IW'(p_l);
  // data positions fill the disks in ascending order, skipping parity
  assign tgt    = IW'((j_l < p_l) ? j_l : j_l + 1'b1);
endmodule

// File: rtl/stripe_xor.sv
// Masked XOR reduction across the disk words.
module stripe_xor #(
  parameter int ND = 4,
  parameter int DW = 32
) (
  input  logic [ND-1:0][DW-1:0] word,
  input  logic [ND-1:0]         sel,
  output logic [DW-1:0]         folded
);
  logic [ND:0][DW-1:0] chain;

  assign chain[0] = '0;
  for (genvar g = 0; g < ND; g++) begin : g_fold
    assign chain[g+1] = chain[g] ^ (sel[g] ? word[g] : '0);
  end
  assign folded = chain[ND];
endmodule

// File: rtl/stripe_ctrl.sv
module stripe_ctrl
  import stripe_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 32,
  parameter int SW = 10,
  parameter int LW = SW + $clog2(N),
  localparam int ND = N + 1,
  localparam int IW = $clog2(N + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_valid,
  output logic                 host_ready,
  input  logic                 host_write,
  input  logic [LW-1:0]        host_lba,
  input  logic [DW-1:0]        host_wdata,
  output logic                 resp_valid,
  output logic                 resp_err,
  output logic [DW-1:0]        resp_rdata,
  input  logic [ND-1:0]        disk_bad,
  output logic [ND-1:0]        dk_req,
  output logic                 dk_we,
  output logic [SW-1:0]        dk_addr,
  output logic [ND-1:0][DW-1:0] dk_wdata,
  input  logic [ND-1:0]        dk_ack,
  input  logic [ND-1:0][DW-1:0] dk_rdata
);
  seq_t                 st;
  logic                 wr_q;
  logic [IW-1:0]        tgt_q, par_q;
  logic [SW-1:0]        str_q;
  logic [DW-1:0]        new_q;
  logic [ND-1:0]        pend, rmask;
  logic [ND-1:0][DW-1:0] cap, wd;

  logic [SW-1:0]        m_str;
  logic [IW-1:0]        m_tgt, m_par;
  logic [DW-1:0]        fold_out;
  logic [ND-1:0]        tmask, pmask, plan_mask;
  logic                 err_now;

  stripe_map #(.N(N), .LW(LW), .SW(SW), .IW(IW)) u_map (
    .lba(host_lba), .stripe(m_str), .tgt(m_tgt), .par(m_par)
  );

  stripe_xor #(.ND(ND), .DW(DW)) u_fold (
    .word(cap), .sel(rmask), .folded(fold_out)
  );

  assign tmask   = ND'(1) << m_tgt;
  assign pmask   = ND'(1) << m_par;
  assign err_now = ($countones(disk_bad) > 1) || (host_write && disk_bad[m_tgt]);

  // disks touched in the read phase (and again in the write phase for writes)
  always_comb begin
    if (host_write)             plan_mask = tmask | (pmask & ~disk_bad);
    else if (disk_bad[m_tgt])   plan_mask = ~disk_bad;
    else                        plan_mask = tmask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      wr_q       <= 1'b0;
      tgt_q      <= '0;
      par_q      <= '0;
      str_q      <= '0;
      new_q      <= '0;
      pend       <= '0;
      rmask      <= '0;
      cap        <= '0;
      wd         <= '0;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (host_valid) begin
            if (err_now) begin
              resp_valid <= 1'b1;
              resp_err   <= 1'b1;
              resp_rdata <= '0;
            end else begin
              wr_q  <= host_write;
              tgt_q <= m_tgt;
              par_q <= m_par;
              str_q <= m_str;
              new_q <= host_wdata;
              pend  <= plan_mask;
              rmask <= plan_mask;
              st    <= SQ_READ;
            end
          end
        end
        SQ_READ: begin
          if (pend == '0) begin
            if (wr_q) begin
              wd[tgt_q] <= new_q;
              wd[par_q] <= cap[par_q] ^ cap[tgt_q] ^ new_q;
              pend      <= rmask;
              st        <= SQ_WRITE;
            end else begin
              resp_valid <= 1'b1;
              resp_err   <= 1'b0;
              resp_rdata <= fold_out;
              st         <= SQ_IDLE;
            end
          end else begin
            for (int i = 0; i < ND; i++) begin
              if (pend[i] && dk_ack[i]) begin
                pend[i] <= 1'b0;
                cap[i]  <= dk_rdata[i];
              end
            end
          end
        end
        SQ_WRITE: begin
          if (pend == '0) begin
            resp_valid <= 1'b1;
            resp_err   <= 1'b0;
            resp_rdata <= '0;
            st         <= SQ_IDLE;
          end else begin
            for (int i = 0; i < ND; i++) begin
              if (pend[i] && dk_ack[i]) pend[i] <= 1'b0;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign host_ready = (st == SQ_IDLE);
  assign dk_req     = pend;
  assign dk_we      = (st == SQ_WRITE);
  assign dk_addr    = str_q;
  assign dk_wdata   = wd;

  // R8: an unacknowledged request is kept until its acknowledge
  p_req_held_r8: assert property (@(posedge clk) disable iff (rst)
    (|(dk_req & ~dk_ack)) |=>
      ((dk_req & $past(dk_req & ~dk_ack)) == $past(dk_req & ~dk_ack)));

  // R8: command and address stay put while a request waits
  p_cmd_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (|(dk_req & ~dk_ack)) |=> ($stable(dk_we) && $stable(dk_addr)));

  // R7: no new request is accepted while disks are busy
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (|dk_req) |-> !host_ready);

  // R6: a disk marked failed is never addressed
  p_no_failed_access_r6: assert property (@(posedge clk) disable iff (rst)
    (|dk_req) |-> ((dk_req & disk_bad) == '0));

  // R5: a healthy read touches one disk only
  p_single_read_r5: assert property (@(posedge clk) disable iff (rst)
    ((|dk_req) && !dk_we && !wr_q && (disk_bad == '0)) |-> $onehot(dk_req));

  // R4: the write phase touches at most the data and parity disks
  p_write_pair_r4: assert property (@(posedge clk) disable iff (rst)
    ((|dk_req) && dk_we) |-> ($countones(dk_req) <= 2));
endmodule

// File: tb/stripe_ctrl_test.sv
module stripe_ctrl_test;
  localparam int N  = 3;
  localparam int DW = 16;
  localparam int SW = 4;
  localparam int LW = 6;
  localparam int ND = N + 1;
  localparam int NS = 1 << SW;
  localparam int NB = N * NS;
  localparam int NV = 26;

  // {write, lba, data, failed mask}
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 6'd0,  16'h1111, 4'b0000},
    {1'b1, 6'd1,  16'h2222, 4'b0000},
    {1'b1, 6'd2,  16'h4444, 4'b0000},
    {1'b0, 6'd1,  16'h0000, 4'b0000},
    {1'b1, 6'd4,  16'hA5A5, 4'b0000},
    {1'b1, 6'd5,  16'h0F0F, 4'b0000},
    {1'b1, 6'd7,  16'h1234, 4'b0000},
    {1'b1, 6'd9,  16'hBEEF, 4'b0000},
    {1'b1, 6'd11, 16'hCAFE, 4'b0000},
    {1'b0, 6'd5,  16'h0000, 4'b0000},
    {1'b0, 6'd1,  16'h0000, 4'b0010},
    {1'b0, 6'd5,  16'h0000, 4'b1000},
    {1'b0, 6'd9,  16'h0000, 4'b0010},
    {1'b1, 6'd6,  16'h3333, 4'b0100},
    {1'b0, 6'd6,  16'h0000, 4'b0001},
    {1'b0, 6'd7,  16'h0000, 4'b0100},
    {1'b1, 6'd4,  16'h7777, 4'b0010},
    {1'b0, 6'd0,  16'h0000, 4'b0011},
    {1'b1, 6'd0,  16'h6666, 4'b0101},
    {1'b1, 6'd47, 16'hD00D, 4'b0000},
    {1'b0, 6'd47, 16'h0000, 4'b1000},
    {1'b0, 6'd8,  16'h0000, 4'b0000},
    {1'b1, 6'd3,  16'h5555, 4'b0100},
    {1'b0, 6'd3,  16'h0000, 4'b0000},
    {1'b1, 6'd0,  16'hABCD, 4'b0000},
    {1'b0, 6'd2,  16'h0000, 4'b0100}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                  rst;
  logic                  host_valid, host_ready, host_write;
  logic [LW-1:0]         host_lba;
  logic [DW-1:0]         host_wdata;
  logic                  resp_valid, resp_err;
  logic [DW-1:0]         resp_rdata;
  logic [ND-1:0]         disk_bad;
  logic [ND-1:0]         dk_req;
  logic                  dk_we;
  logic [SW-1:0]         dk_addr;
  logic [ND-1:0][DW-1:0] dk_wdata;
  logic [ND-1:0]         dk_ack;
  logic [ND-1:0][DW-1:0] dk_rdata;

  stripe_ctrl #(.N(N), .DW(DW), .SW(SW), .LW(LW)) uut (
    .clk(clk), .rst(rst),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_lba(host_lba), .host_wdata(host_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .disk_bad(disk_bad), .dk_req(dk_req), .dk_we(dk_we), .dk_addr(dk_addr),
    .dk_wdata(dk_wdata), .dk_ack(dk_ack), .dk_rdata(dk_rdata)
  );

  // disk models: disk i answers i+1 cycles after the request appears
  logic [DW-1:0] mem [ND][NS];
  int            dcnt [ND];

  always @(posedge clk) begin
    for (int i = 0; i < ND; i++) begin
      if (rst) begin
        dk_ack[i]   <= 1'b0;
        dk_rdata[i] <= '0;
        dcnt[i]     <= 0;
        for (int s = 0; s < NS; s++) mem[i][s] <= '0;
      end else if (dk_req[i] && !dk_ack[i]) begin
        if (dcnt[i] >= i + 1) begin
          dk_ack[i] <= 1'b1;
          dcnt[i]   <= 0;
          if (dk_we) mem[i][dk_addr] <= dk_wdata[i];
          else       dk_rdata[i]     <= mem[i][dk_addr];
        end else begin
          dcnt[i] <= dcnt[i] + 1;
        end
      end else begin
        dk_ack[i] <= 1'b0;
      end
    end
  end

  // access monitor
  int            rd_cnt [ND];
  int            wr_cnt [ND];
  int            order_bad, drop_bad, busy_ready;
  logic          seen_wr;
  logic [ND-1:0] req_prev, ack_prev;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ND; i++) begin
        rd_cnt[i] <= 0;
        wr_cnt[i] <= 0;
      end
      order_bad  <= 0;
      drop_bad   <= 0;
      busy_ready <= 0;
      seen_wr    <= 1'b0;
      req_prev   <= '0;
      ack_prev   <= '0;
    end else begin
      if (host_valid && host_ready) seen_wr <= 1'b0;
      for (int i = 0; i < ND; i++) begin
        if (dk_req[i] && dk_ack[i]) begin
          if (dk_we) begin
            wr_cnt[i] <= wr_cnt[i] + 1;
            seen_wr   <= 1'b1;
          end else begin
            rd_cnt[i] <= rd_cnt[i] + 1;
          end
        end
      end
      if ((|(dk_req & dk_ack)) && !dk_we && seen_wr) order_bad <= order_bad + 1;
      if ((req_prev & ~dk_req & ~ack_prev) != '0) drop_bad <= drop_bad + 1;
      if ((|dk_req) && host_ready) busy_ready <= busy_ready + 1;
      req_prev <= dk_req;
      ack_prev <= dk_ack;
    end
  end

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] shadow [NB];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic wr, input int lba, input logic [DW-1:0] data,
                        input logic [ND-1:0] bad);
    int s, j, p, t, nf;
    bit err_exp, got;
    logic [ND-1:0] rdm, wrm, act_rd, act_wr;
    int rd0 [ND];
    int wr0 [ND];
    int ord0, sum_rd, sum_wr;
    logic [DW-1:0] got_data, xr;
    logic got_err;
    string tag;

    s  = lba / N;
    j  = lba % N;
    p  = N - (s % (N + 1));
    t  = (j < p) ? j : j + 1;
    nf = $countones(bad);
    err_exp = (nf > 1) || (wr && bad[t]);
    if (err_exp) begin
      rdm = '0; wrm = '0;
    end else if (wr) begin
      rdm = ND'(1) << t;
      if (!bad[p]) rdm = rdm | (ND'(1) << p);
      wrm = rdm;
    end else if (bad[t]) begin
      rdm = ~bad; wrm = '0;
    end else begin
      rdm = ND'(1) << t; wrm = '0;
    end
    if (nf > 1)                tag = "R10";
    else if (err_exp)          tag = "R9";
    else if (wr && bad[p])     tag = "R11";
    else if (wr)               tag = "R4";
    else if (bad[t])           tag = "R6";
    else                       tag = "R5";

    for (int i = 0; i < ND; i++) begin
      rd0[i] = rd_cnt[i];
      wr0[i] = wr_cnt[i];
    end
    ord0 = order_bad;

    @(negedge clk);
    disk_bad   = bad;
    host_write = wr;
    host_lba   = LW'(lba);
    host_wdata = data;
    host_valid = 1'b1;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    got = 1'b0;
    got_data = '0;
    got_err = 1'b0;
    for (int k = 0; k < 400 && !got; k++) begin
      if (resp_valid) begin
        got = 1'b1;
        got_data = resp_rdata;
        got_err = resp_err;
      end else begin
        @(negedge clk);
      end
    end
    chk(got, "R7", "response pulse seen", 32'(got), 32'd1);

    chk(got_err == err_exp, (nf > 1) ? "R10" : (err_exp ? "R9" : "R7"),
        "error flag", 32'(got_err), 32'(err_exp));

    if (!wr && !err_exp)
      chk(got_data == shadow[lba], bad[t] ? "R6" : "R5", "read data",
          32'(got_data), 32'(shadow[lba]));

    act_rd = '0; act_wr = '0; sum_rd = 0; sum_wr = 0;
    for (int i = 0; i < ND; i++) begin
      act_rd[i] = (rd_cnt[i] != rd0[i]);
      act_wr[i] = (wr_cnt[i] != wr0[i]);
      sum_rd += rd_cnt[i] - rd0[i];
      sum_wr += wr_cnt[i] - wr0[i];
    end
    chk((act_rd == rdm) && (act_wr == wrm) &&
        (sum_rd == $countones(rdm)) && (sum_wr == $countones(wrm)),
        tag, "access pattern {wr,rd}",
        32'({act_wr, act_rd}), 32'({wrm, rdm}));

    if (wr && !err_exp) begin
      chk(order_bad == ord0, "R4", "reads finish before writes",
          32'(order_bad - ord0), 32'd0);
      chk(mem[t][s] == data, "R1", "data on mapped disk",
          32'(mem[t][s]), 32'(data));
      if (!bad[p])
        chk(act_wr[p], "R2", "parity disk written", 32'(act_wr), 32'(ND'(1) << p));
      if (bad == '0) begin
        xr = '0;
        for (int i = 0; i < ND; i++) xr ^= mem[i][s];
        chk(xr == '0, "R3", "stripe XOR after write", 32'(xr), 32'd0);
      end
      shadow[lba] = data;
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) shadow[b] = '0;
    rst        = 1'b1;
    host_valid = 1'b0;
    host_write = 1'b0;
    host_lba   = '0;
    host_wdata = '0;
    disk_bad   = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12: reset state
    chk(host_ready == 1'b1, "R12", "ready after reset", 32'(host_ready), 32'd1);
    chk(dk_req == '0, "R12", "no disk request after reset", 32'(dk_req), 32'd0);
    chk(resp_valid == 1'b0, "R12", "no response after reset", 32'(resp_valid), 32'd0);

    for (int v = 0; v < NV; v++)
      run_op(VEC[v][26], int'(VEC[v][25:20]), VEC[v][19:4], VEC[v][3:0]);

    // R1 / R2: direct mapping of the last stripe (s=15, parity on disk 0)
    run_op(1'b1, 46, 16'h0BAD, 4'b0000);
    chk(mem[2][15] == 16'h0BAD, "R1", "lba 46 on disk 2", 32'(mem[2][15]), 32'h0BAD);
    chk(mem[0][15] == (16'h0BAD ^ 16'hD00D), "R2", "stripe 15 parity on disk 0",
        32'(mem[0][15]), 32'(16'h0BAD ^ 16'hD00D));

    // R8 / R7: handshake discipline across the whole run
    chk(drop_bad == 0, "R8", "requests dropped without acknowledge", 32'(drop_bad), 32'd0);
    chk(busy_ready == 0, "R7", "ready high while disks busy", 32'(busy_ready), 32'd0);
    chk(order_bad == 0, "R4", "total read-after-write ordering faults", 32'(order_bad), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule